// File: doc/BRIEF.md
# Skip and Jump-and-Link Next-PC Unit

This block works out where the fetch stream goes next on a 16-bit machine that has no condition flags. Such a machine has only two control-flow instructions. The first is a compare-and-skip instruction. When its condition holds, the instruction that follows is not executed. The second is a jump that always writes a return address. For each instruction it is handed, the unit produces the following program counter, the link-register write (enable and value), a flag that says the next instruction is to be squashed, and a flag for a register jump target that was not aligned.

The block is driven one instruction at a time through a step strobe. A decoder in front of it supplies these inputs:
- the instruction class;
- the three-bit condition field;
- the first source register value;
- the second operand, which is either the second register or the already sign-extended immediate;
- the raw 11-bit jump offset;
- the register-form select;
- whether the instruction being presented is a prefix.

A skip that fires marks the next instruction as squashed. If that squashed instruction is a prefix, the squash carries on to the instruction after it, so the prefix and the instruction it extends go together. All outputs are registered. The surrounding core feeds `npc_o` back as the next `pc_i`.

Top module: `brlink_pc_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the outputs read `npc_o` = RESET_PC (default 0x0000), with `link_we_o`, `skip_pend_o` and `misalign_o` all 0.
- R2: On a step with no squash pending and class 0 or 3 (not a control instruction), the following cycle shows `npc_o` = `pc_i` + 2 and `link_we_o` = 0.
- R3: Class 1 (skip) with condition 0 fires when `rs1_i` == `opnd2_i`. Condition 1 fires when they differ. "Fires" means `skip_pend_o` reads 1 in the following cycle. The PC still advances by 2 and no link write is made.
- R4: Condition 4 fires when `rs1_i` < `opnd2_i` as signed two's-complement values. Condition 5 fires when `rs1_i` >= `opnd2_i` as signed values.
- R5: Condition 6 fires when `rs1_i` < `opnd2_i` as unsigned values. Condition 7 fires when `rs1_i` >= `opnd2_i` as unsigned values.
- R6: Conditions 2 and 3 never fire, whatever the operands are.
- R7: A step taken while `skip_pend_o` is 1 is squashed. It gives `npc_o` = `pc_i` + 2, `link_we_o` = 0 and `misalign_o` = 0, even when its class is jump. `skip_pend_o` then drops to 0 unless R8 applies.
- R8: If a squashed step has `is_prefix_i` = 1, `skip_pend_o` stays 1, so the instruction after the prefix is squashed too.
- R9: A jump (class 2) that is not squashed pulses `link_we_o` = 1 for one cycle, with `link_val_o` = `pc_i` + 2.
- R10: A jump with `use_rs2_i` = 0 goes to `pc_i` + 2 + 2 × sign-extended `jimm_i`, with the sum wrapping modulo 2^16.
- R11: A jump with `use_rs2_i` = 1 goes to `opnd2_i` with bit 0 cleared. `misalign_o` is 1 exactly when bit 0 of `opnd2_i` was set.
- R12: A cycle with `step_i` = 0 leaves `npc_o`, `skip_pend_o`, `link_val_o` and `misalign_o` unchanged, and drives `link_we_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Evaluate the presented instruction this cycle |
| pc_i | input | 16 | Address of the presented instruction |
| op_kind_i | input | 2 | Class: 0 other, 1 skip, 2 jump-and-link, 3 other |
| cond_i | input | 3 | Skip condition: 0 eq, 1 ne, 2/3 unused, 4 lt, 5 ge, 6 ltu, 7 geu |
| rs1_i | input | 16 | First source register value |
| opnd2_i | input | 16 | Second register value or sign-extended immediate |
| jimm_i | input | 11 | Signed jump offset in instruction units |
| use_rs2_i | input | 1 | Jump target comes from `opnd2_i` |
| is_prefix_i | input | 1 | The presented instruction is a prefix |
| npc_o | output | 16 | Next program counter |
| link_we_o | output | 1 | Link register write strobe |
| link_val_o | output | 16 | Return address to write to the link register |
| skip_pend_o | output | 1 | The next instruction will be squashed |
| misalign_o | output | 1 | Register jump target had bit 0 set |

## Verification
The bench uses the default build: 16-bit words, 2-byte instructions and an 11-bit jump offset. With these values, PC wrap-around at 0xFFFE and the most negative offset (-1024) are reachable in a few steps. The signed and unsigned orderings are exercised at 0x8000 against 0x0001, where the two orderings disagree. Prefix chains of length two and more are driven directly, so the extended squash can be seen in `skip_pend_o`. Random mixes of classes are interleaved with idle cycles.

// File: rtl/brlink_pkg.sv
package brlink_pkg;

  typedef enum logic [1:0] {
    OPK_PLAIN  = 2'd0,
    OPK_SKIP   = 2'd1,
    OPK_JAL    = 2'd2,
    OPK_PLAIN2 = 2'd3
  } opk_e;

  typedef enum logic [2:0] {
    CND_EQ   = 3'd0,
    CND_NE   = 3'd1,
    CND_RSV2 = 3'd2,
    CND_RSV3 = 3'd3,
    CND_LT   = 3'd4,
    CND_GE   = 3'd5,
    CND_LTU  = 3'd6,
    CND_GEU  = 3'd7
  } cnd_e;

endpackage

// File: rtl/brlink_cond_eval.sv
module brlink_cond_eval
  import brlink_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [2:0]      cond_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            take_o
);

  logic eq_w, slt_w, ult_w;

  assign eq_w  = (a_i == b_i);
  assign slt_w = ($signed(a_i) < $signed(b_i));
  assign ult_w = (a_i < b_i);

  always_comb begin
    take_o = 1'b0;
    case (cnd_e'(cond_i))
      CND_EQ:  take_o = eq_w;
      CND_NE:  take_o = !eq_w;
      CND_LT:  take_o = slt_w;
      CND_GE:  take_o = !slt_w;
      CND_LTU: take_o = ult_w;
      CND_GEU: take_o = !ult_w;
      default: take_o = 1'b0;
    endcase
  end

  // R6
  always_comb begin
    rsv_never_chk: assert (!(cond_i[2:1] == 2'b01 && take_o));
  end

endmodule

// File: rtl/brlink_target_gen.sv
module brlink_target_gen #(
  parameter int XLEN       = 16,
  parameter int JIMM_W     = 11,
  parameter int INSN_BYTES = 2
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   opnd2_i,
  input  logic [JIMM_W-1:0] jimm_i,
  input  logic              use_rs2_i,
  output logic [XLEN-1:0]   seq_pc_o,
  output logic [XLEN-1:0]   jal_tgt_o,
  output logic              misalign_o
);

  localparam int              SHIFT  = $clog2(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] AMASK  = XLEN'(INSN_BYTES - 1);

  logic [XLEN-1:0] jext_w;
  logic [XLEN-1:0] rel_w;
  logic [XLEN-1:0] reg_w;

  assign seq_pc_o = pc_i + STEP_V;
  assign jext_w   = {{(XLEN-JIMM_W){jimm_i[JIMM_W-1]}}, jimm_i};
  assign rel_w    = seq_pc_o + (jext_w << SHIFT);
  assign reg_w    = opnd2_i & ~AMASK;

  assign jal_tgt_o  = use_rs2_i ? reg_w : rel_w;
  assign misalign_o = use_rs2_i && ((opnd2_i & AMASK) != '0);

  // R11
  always_comb begin
    reg_aligned_chk: assert (!use_rs2_i || ((jal_tgt_o & AMASK) == '0));
  end

endmodule

// File: rtl/brlink_pc_unit.sv
module brlink_pc_unit
  import brlink_pkg::*;
#(
  parameter int              XLEN       = 16,
  parameter int              JIMM_W     = 11,
  parameter int              INSN_BYTES = 2,
  parameter logic [XLEN-1:0] RESET_PC   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [1:0]        op_kind_i,
  input  logic [2:0]        cond_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   opnd2_i,
  input  logic [JIMM_W-1:0] jimm_i,
  input  logic              use_rs2_i,
  input  logic              is_prefix_i,
  output logic [XLEN-1:0]   npc_o,
  output logic              link_we_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              skip_pend_o,
  output logic              misalign_o
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(INSN_BYTES);

  logic            take_w;
  logic [XLEN-1:0] seq_pc_w, jal_tgt_w;
  logic            tgt_mis_w;

  logic [XLEN-1:0] npc_d;
  logic            lw_d, pend_d, mis_d;

  logic [XLEN-1:0] npc_q, link_val_q;
  logic            link_we_q, pend_q, mis_q;

  brlink_cond_eval #(.XLEN(XLEN)) u_cond (
    .cond_i (cond_i),
    .a_i    (rs1_i),
    .b_i    (opnd2_i),
    .take_o (take_w)
  );

  brlink_target_gen #(
    .XLEN(XLEN), .JIMM_W(JIMM_W), .INSN_BYTES(INSN_BYTES)
  ) u_tgt (
    .pc_i       (pc_i),
    .opnd2_i    (opnd2_i),
    .jimm_i     (jimm_i),
    .use_rs2_i  (use_rs2_i),
    .seq_pc_o   (seq_pc_w),
    .jal_tgt_o  (jal_tgt_w),
    .misalign_o (tgt_mis_w)
  );

  always_comb begin
    npc_d  = seq_pc_w;
    lw_d   = 1'b0;
    pend_d = 1'b0;
    mis_d  = 1'b0;
    if (pend_q) begin
      pend_d = is_prefix_i;
    end else begin
      case (opk_e'(op_kind_i))
        OPK_SKIP: pend_d = take_w;
        OPK_JAL: begin
          lw_d  = 1'b1;
          npc_d = jal_tgt_w;
          mis_d = tgt_mis_w;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_q      <= RESET_PC;
      link_we_q  <= 1'b0;
      link_val_q <= '0;
      pend_q     <= 1'b0;
      mis_q      <= 1'b0;
    end else begin
      link_we_q <= 1'b0;
      if (step_i) begin
        npc_q     <= npc_d;
        link_we_q <= lw_d;
        pend_q    <= pend_d;
        mis_q     <= mis_d;
        if (lw_d) link_val_q <= seq_pc_w;
      end
    end
  end

  assign npc_o       = npc_q;
  assign link_we_o   = link_we_q;
  assign link_val_o  = link_val_q;
  assign skip_pend_o = pend_q;
  assign misalign_o  = mis_q;

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !pend_q && !op_kind_i[0] && !op_kind_i[1])
      |=> (npc_o == $past(pc_i) + STEP_V && !link_we_o));

  // R6
  rsv_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !pend_q && op_kind_i == 2'd1 && cond_i[2:1] == 2'b01)
      |=> !skip_pend_o);

  // R7
  squash_no_link_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && pend_q) |=> (!link_we_o && !misalign_o));

  // R8
  prefix_extend_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && pend_q && is_prefix_i) |=> skip_pend_o);

  // R9
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !pend_q && op_kind_i == 2'd2)
      |=> (link_we_o && link_val_o == $past(pc_i) + STEP_V));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(npc_o) && $stable(skip_pend_o) && !link_we_o));

endmodule

// File: tb/brlink_pc_unit_bench.sv
module brlink_pc_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [1:0]  op_kind_i = '0;
  logic [2:0]  cond_i = '0;
  logic [15:0] rs1_i = '0;
  logic [15:0] opnd2_i = '0;
  logic [10:0] jimm_i = '0;
  logic        use_rs2_i = 1'b0;
  logic        is_prefix_i = 1'b0;
  logic [15:0] npc_o, link_val_o;
  logic        link_we_o, skip_pend_o, misalign_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] m_npc = 16'h0000;
  logic [15:0] m_lv  = 16'h0000;
  logic        m_lw  = 1'b0;
  logic        m_pend = 1'b0;
  logic        m_mis = 1'b0;

  always #2.5 clk = ~clk;

  brlink_pc_unit u_brlink_pc_unit (
    .clk(clk), .rst(rst), .step_i(step_i), .pc_i(pc_i),
    .op_kind_i(op_kind_i), .cond_i(cond_i), .rs1_i(rs1_i),
    .opnd2_i(opnd2_i), .jimm_i(jimm_i), .use_rs2_i(use_rs2_i),
    .is_prefix_i(is_prefix_i), .npc_o(npc_o), .link_we_o(link_we_o),
    .link_val_o(link_val_o), .skip_pend_o(skip_pend_o),
    .misalign_o(misalign_o)
  );

  function automatic bit cond_true(input logic [2:0] c, input logic [15:0] a,
                                   input logic [15:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_step(input logic st, input logic [1:0] k, input logic [2:0] c,
                         input logic [15:0] pc, input logic [15:0] a,
                         input logic [15:0] b, input logic [10:0] ji,
                         input logic ur, input logic pfx);
    string tag;
    logic [15:0] jext;
    @(negedge clk);
    step_i = st; op_kind_i = k; cond_i = c; pc_i = pc; rs1_i = a;
    opnd2_i = b; jimm_i = ji; use_rs2_i = ur; is_prefix_i = pfx;
    m_lw = 1'b0;
    if (!st) tag = "R12";
    else if (m_pend) begin
      tag = pfx ? "R8" : "R7";
      m_npc = pc + 16'd2; m_mis = 1'b0; m_pend = pfx;
    end else begin
      m_npc = pc + 16'd2; m_mis = 1'b0; m_pend = 1'b0;
      case (k)
        2'd1: begin
          m_pend = cond_true(c, a, b);
          case (c)
            3'd0, 3'd1: tag = "R3";
            3'd4, 3'd5: tag = "R4";
            3'd6, 3'd7: tag = "R5";
            default:    tag = "R6";
          endcase
        end
        2'd2: begin
          m_lw = 1'b1; m_lv = pc + 16'd2;
          jext = {{5{ji[10]}}, ji};
          if (ur) begin
            tag = "R11"; m_npc = {b[15:1], 1'b0}; m_mis = b[0];
          end else begin
            tag = "R10"; m_npc = pc + 16'd2 + (jext << 1);
          end
        end
        default: tag = "R2";
      endcase
    end
    @(posedge clk);
    #1;
    chk(tag, "npc", npc_o, m_npc);
    chk(tag, "pend", {15'd0, skip_pend_o}, {15'd0, m_pend});
    chk(tag, "misalign", {15'd0, misalign_o}, {15'd0, m_mis});
    chk(m_lw ? "R9" : tag, "link_we", {15'd0, link_we_o}, {15'd0, m_lw});
    if (m_lw) chk("R9", "link_val", link_val_o, m_lv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", "npc", npc_o, 16'h0000);
    chk("R1", "link_we", {15'd0, link_we_o}, 16'd0);
    chk("R1", "pend", {15'd0, skip_pend_o}, 16'd0);
    chk("R1", "misalign", {15'd0, misalign_o}, 16'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2 plain sequential, including wrap
    do_step(1, 2'd0, 3'd0, 16'h0100, 16'h0, 16'h0, 11'h0, 0, 0);
    do_step(1, 2'd3, 3'd0, 16'hFFFE, 16'h0, 16'h0, 11'h0, 0, 0);
    // R3 eq taken then squash plain (R7)
    do_step(1, 2'd1, 3'd0, 16'h0200, 16'h1234, 16'h1234, 11'h0, 0, 0);
    do_step(1, 2'd0, 3'd0, 16'h0202, 16'h0, 16'h0, 11'h0, 0, 0);
    do_step(1, 2'd1, 3'd1, 16'h0204, 16'h1234, 16'h1234, 11'h0, 0, 0);
    // R4 / R5 at 0x8000 vs 1
    do_step(1, 2'd1, 3'd6, 16'h0206, 16'h8000, 16'h0001, 11'h0, 0, 0);
    do_step(1, 2'd1, 3'd4, 16'h0208, 16'h8000, 16'h0001, 11'h0, 0, 0);
    do_step(1, 2'd0, 3'd0, 16'h020A, 16'h0, 16'h0, 11'h0, 0, 0);
    do_step(1, 2'd1, 3'd7, 16'h020C, 16'h8000, 16'h0001, 11'h0, 0, 0);
    do_step(1, 2'd0, 3'd0, 16'h020E, 16'h0, 16'h0, 11'h0, 0, 0);
    // R6 unused codes never fire
    do_step(1, 2'd1, 3'd2, 16'h0210, 16'h5, 16'h5, 11'h0, 0, 0);
    do_step(1, 2'd1, 3'd3, 16'h0212, 16'h5, 16'h9, 11'h0, 0, 0);
    // R7 squashed jal makes no link write
    do_step(1, 2'd1, 3'd5, 16'h0214, 16'h0003, 16'hFFFF, 11'h0, 0, 0);
    do_step(1, 2'd2, 3'd0, 16'h0216, 16'h0, 16'h0301, 11'h7FF, 1, 0);
    // R8 squashed prefix chain
    do_step(1, 2'd1, 3'd0, 16'h0300, 16'h7, 16'h7, 11'h0, 0, 0);
    do_step(1, 2'd0, 3'd0, 16'h0302, 16'h0, 16'h0, 11'h0, 0, 1);
    do_step(1, 2'd0, 3'd0, 16'h0304, 16'h0, 16'h0, 11'h0, 0, 1);
    do_step(1, 2'd2, 3'd0, 16'h0306, 16'h0, 16'h0, 11'h010, 0, 0);
    // R10 most negative offset with wrap; R9 link
    do_step(1, 2'd2, 3'd0, 16'h0002, 16'h0, 16'h0, 11'h400, 0, 0);
    do_step(1, 2'd2, 3'd0, 16'hFFFC, 16'h0, 16'h0, 11'h003, 0, 0);
    // R11 odd register target
    do_step(1, 2'd2, 3'd0, 16'h1000, 16'h0, 16'h4321, 11'h0, 1, 0);
    do_step(1, 2'd2, 3'd0, 16'h1002, 16'h0, 16'h4320, 11'h0, 1, 0);
    // R12 idle holds, then idle while pending
    do_step(1, 2'd2, 3'd0, 16'h2000, 16'h0, 16'h0123, 11'h0, 1, 0);
    do_step(0, 2'd2, 3'd0, 16'h3000, 16'h0, 16'h0, 11'h1, 0, 0);
    do_step(1, 2'd1, 3'd0, 16'h3000, 16'h1, 16'h1, 11'h0, 0, 0);
    do_step(0, 2'd0, 3'd0, 16'h3002, 16'h0, 16'h0, 11'h0, 0, 1);
    do_step(1, 2'd0, 3'd0, 16'h3002, 16'h0, 16'h0, 11'h0, 0, 0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = ($urandom % 4 == 0) ? a : 16'($urandom);
      if ($urandom % 6 == 0) b = a ^ 16'h8000;
      do_step(($urandom % 8) != 0, 2'($urandom), 3'($urandom),
              16'($urandom) & 16'hFFFE, a, b, 11'($urandom),
              1'($urandom), ($urandom % 3) == 0);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule